// File: doc/BRIEF.md
# Crosspoint Command Port over a Two-Wire Serial Bus

This block is the serial front end of a crosspoint switch controller. It sits on a two-wire I2C-compatible bus as a slave. It oversamples SCL and SDA in the system clock domain and finds START and STOP conditions. It answers only to its own 7-bit address. That address is the fixed prefix `1110` followed by three strap inputs.

A write frame carries exactly two data bytes after the address. The block joins them into one 16-bit command word. It hands that word to the switch register bank with a one-cycle strobe. A read frame returns two bytes: first a byte of zeros, then a status byte that the register bank supplies. SDA is driven open-drain: the block can only pull the line low or release it.

The command output is a plain valid strobe with no ready input. The bus has no clock stretching, so the block cannot hold a frame back. The consumer must accept the word in the cycle the strobe is high. Data flowing into the block has no back-pressure either: the master sets the pace.

Top module: `xpt_i2c_cmd_port`

## Requirements
- R1: The device address is 7 bits, `{1,1,1,0,dev_sel[2],dev_sel[1],dev_sel[0]}`. It is received MSB first, and the R/W bit follows it. On a match, the block holds SDA low through the ninth SCL pulse (ACK).
- R2: When the address does not match, the block never pulls SDA low and emits no command until the next START.
- R3: In a write frame (R/W = 0), both data bytes are acknowledged. The first byte becomes `cmd_word[15:8]` and the second becomes `cmd_word[7:0]`. `cmd_valid` is high for exactly one clock per completed frame.
- R4: A STOP that arrives before the second data byte is complete discards the partial word, and no `cmd_valid` is raised.
- R5: Any data byte after the second in a write frame is not acknowledged and raises no `cmd_valid`.
- R6: In a read frame (R/W = 1), the block sends 8'h00 first. Then it sends `status_byte`, MSB first, as sampled at the end of the master's ACK to the first byte.
- R7: If the master NACKs a read byte, the block releases SDA and drives nothing more until a new START.
- R8: `sda_pull_low` changes only while the sampled SCL is low. SDA is never driven high.
- R9: While `rst_n` is low, the block is idle, SDA is released, `cmd_valid` is low, and bus traffic has no effect.
- R10: A repeated START in the middle of a frame restarts the address phase and drops any partial word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel | input | 3 | Strapped low three address bits |
| status_byte | input | 8 | Status returned in the second read byte |
| cmd_valid | output | 1 | One-cycle strobe for a new command word |
| cmd_word | output | 16 | Command word, valid while `cmd_valid` is high |

## Verification
The bench runs the following corner cases, each against a specific wrong design:
- A write aborted by STOP after one byte. A design that kept the partial word would emit a stale command.
- A third write byte. A design that kept acknowledging would reload half of the word.
- A repeated START in mid-frame. A design that missed it would join old and new bytes into one word.
- A foreign address. A wrong match would pull SDA low and corrupt another device's transfer.
- A NACK after the first read byte. A design that kept driving would send status bits into the following clocks.
- Traffic during reset. A design not held idle would raise a command.
- Two strap settings with different status values. These expose a swapped address bit or a bit-order error in the readback.

// File: rtl/xpt_i2c_pkg.sv
package xpt_i2c_pkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_W      = 7;
  localparam int STRAP_W     = 3;
  localparam logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 4'b1110;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_ACK,
    PH_WR_BITS,
    PH_WR_ACK,
    PH_RD_BITS,
    PH_RD_ACK,
    PH_SKIP
  } bus_phase_e;
endpackage

// File: rtl/xpt_bus_sampler.sv
module xpt_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_up,
  output logic scl_down,
  output logic start_seen,
  output logic stop_seen
);
  localparam int LINES = 2;

  logic [LINES-1:0] stage_q [STAGES];
  logic [LINES-1:0] last_q;
  logic [LINES-1:0] now_v;

  // Synchroniser chain; idle bus level is high on both lines.
  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q[k] <= '1;
        end else if (k == 0) begin
          stage_q[k] <= {scl_raw, sda_raw};
        end else begin
          stage_q[k] <= stage_q[(k == 0) ? 0 : k-1];
        end
      end
    end
  endgenerate

  assign now_v = stage_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '1;
    else        last_q <= now_v;
  end

  assign scl_lvl    = now_v[1];
  assign sda_lvl    = now_v[0];
  assign scl_up     = now_v[1] & ~last_q[1];
  assign scl_down   = ~now_v[1] & last_q[1];
  assign start_seen = now_v[1] & last_q[1] & last_q[0] & ~now_v[0];
  assign stop_seen  = now_v[1] & last_q[1] & ~last_q[0] & now_v[0];

  // R8: the two line conditions can never be reported in the same cycle
  a_r8_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_seen, stop_seen, scl_up, scl_down}) || !(start_seen || stop_seen)
      || (!scl_up && !scl_down));
endmodule

// File: rtl/xpt_addr_match.sv
module xpt_addr_match
  import xpt_i2c_pkg::*;
(
  input  logic [ADDR_W-1:0]  rx_addr,
  input  logic [STRAP_W-1:0] strap,
  output logic               hit
);
  always_comb hit = (rx_addr == {ADDR_PREFIX, strap});
endmodule

// File: rtl/xpt_frame_engine.sv
module xpt_frame_engine
  import xpt_i2c_pkg::*;
#(
  parameter int CMD_BYTES = 2,
  parameter int RD_BYTES  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_lvl,
  input  logic                       sda_lvl,
  input  logic                       scl_up,
  input  logic                       scl_down,
  input  logic                       start_seen,
  input  logic                       stop_seen,
  input  logic                       addr_hit,
  input  logic [BYTE_W-1:0]          status_in,
  output logic [ADDR_W-1:0]          rx_addr,
  output logic                       pull_low,
  output logic                       word_valid,
  output logic [CMD_BYTES*BYTE_W-1:0] word_data
);
  localparam int CMD_W = CMD_BYTES * BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(((CMD_BYTES > RD_BYTES) ? CMD_BYTES : RD_BYTES) + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_WR  = IDX_W'(CMD_BYTES - 1);
  localparam logic [IDX_W-1:0] LAST_RD  = IDX_W'(RD_BYTES - 1);

  bus_phase_e         phase_q;
  logic [CNT_W-1:0]   bit_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BYTE_W-1:0]  rx_q;
  logic [BYTE_W-1:0]  tx_q;
  logic               is_read_q;
  logic               m_ack_q;
  logic [CMD_W-1:0]   acc_q;

  assign rx_addr   = rx_q[BYTE_W-1:1];
  assign word_data = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      bit_q      <= '0;
      idx_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      is_read_q  <= 1'b0;
      m_ack_q    <= 1'b0;
      acc_q      <= '0;
      pull_low   <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (stop_seen) begin
        phase_q  <= PH_IDLE;
        pull_low <= 1'b0;
      end else if (start_seen) begin
        phase_q  <= PH_ADDR;
        bit_q    <= '0;
        idx_q    <= '0;
        pull_low <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_ADDR: begin
            if (scl_up) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl};
              bit_q <= bit_q + 1'b1;
            end else if (scl_down && bit_q == FULL_CNT) begin
              if (addr_hit) begin
                is_read_q <= rx_q[0];
                pull_low  <= 1'b1;
                phase_q   <= PH_ADDR_ACK;
              end else begin
                phase_q   <= PH_SKIP;
              end
            end
          end
          PH_ADDR_ACK: begin
            if (scl_down) begin
              bit_q <= '0;
              idx_q <= '0;
              if (is_read_q) begin
                tx_q     <= '0;
                pull_low <= 1'b1;
                phase_q  <= PH_RD_BITS;
              end else begin
                pull_low <= 1'b0;
                phase_q  <= PH_WR_BITS;
              end
            end
          end
          PH_WR_BITS: begin
            if (scl_up) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_lvl};
              bit_q <= bit_q + 1'b1;
            end else if (scl_down && bit_q == FULL_CNT) begin
              pull_low <= 1'b1;
              phase_q  <= PH_WR_ACK;
              acc_q    <= {acc_q[CMD_W-BYTE_W-1:0], rx_q};
              if (idx_q == LAST_WR) word_valid <= 1'b1;
            end
          end
          PH_WR_ACK: begin
            if (scl_down) begin
              pull_low <= 1'b0;
              bit_q    <= '0;
              if (idx_q == LAST_WR) begin
                phase_q <= PH_SKIP;
              end else begin
                idx_q   <= idx_q + 1'b1;
                phase_q <= PH_WR_BITS;
              end
            end
          end
          PH_RD_BITS: begin
            if (scl_down) begin
              if (bit_q == LAST_BIT) begin
                pull_low <= 1'b0;
                phase_q  <= PH_RD_ACK;
              end else begin
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
                pull_low <= ~tx_q[BYTE_W-2];
                bit_q    <= bit_q + 1'b1;
              end
            end
          end
          PH_RD_ACK: begin
            if (scl_up) begin
              m_ack_q <= ~sda_lvl;
            end else if (scl_down) begin
              if (m_ack_q && idx_q != LAST_RD) begin
                tx_q     <= status_in;
                pull_low <= ~status_in[BYTE_W-1];
                bit_q    <= '0;
                idx_q    <= idx_q + 1'b1;
                phase_q  <= PH_RD_BITS;
              end else begin
                phase_q  <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: the pull-down moves only after SCL was seen low
  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_low != $past(pull_low)) |-> !$past(scl_lvl));

  // R3: the command strobe lasts a single cycle
  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R3: a command completes only in the low phase of SCL
  a_r3_strobe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !scl_lvl);

  // R7: a STOP always leaves SDA released
  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !pull_low);
endmodule

// File: rtl/xpt_i2c_cmd_port.sv
module xpt_i2c_cmd_port
  import xpt_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_BYTES   = 2,
  parameter int RD_BYTES    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_in,
  input  logic                        sda_in,
  output logic                        sda_pull_low,
  input  logic [STRAP_W-1:0]          dev_sel,
  input  logic [BYTE_W-1:0]           status_byte,
  output logic                        cmd_valid,
  output logic [CMD_BYTES*BYTE_W-1:0] cmd_word
);
  logic scl_lvl, sda_lvl, scl_up, scl_down, start_seen, stop_seen;
  logic addr_hit;
  logic [ADDR_W-1:0] rx_addr;

  xpt_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_raw    (scl_in),
    .sda_raw    (sda_in),
    .scl_lvl    (scl_lvl),
    .sda_lvl    (sda_lvl),
    .scl_up     (scl_up),
    .scl_down   (scl_down),
    .start_seen (start_seen),
    .stop_seen  (stop_seen)
  );

  xpt_addr_match u_match (
    .rx_addr (rx_addr),
    .strap   (dev_sel),
    .hit     (addr_hit)
  );

  xpt_frame_engine #(.CMD_BYTES(CMD_BYTES), .RD_BYTES(RD_BYTES)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .sda_lvl    (sda_lvl),
    .scl_up     (scl_up),
    .scl_down   (scl_down),
    .start_seen (start_seen),
    .stop_seen  (stop_seen),
    .addr_hit   (addr_hit),
    .status_in  (status_byte),
    .rx_addr    (rx_addr),
    .pull_low   (sda_pull_low),
    .word_valid (cmd_valid),
    .word_data  (cmd_word)
  );

  // R4: no command can be issued while a STOP is being seen
  a_r4_no_cmd_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !cmd_valid);
endmodule

// File: tb/xpt_i2c_cmd_port_test.sv
module xpt_i2c_cmd_port_test;
  localparam int CLK_NS = 10;
  localparam int Q      = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b101;
  logic [7:0] status_byte = 8'h00;
  logic sda_pull_low, cmd_valid;
  logic [15:0] cmd_word;
  logic sda_line;

  int total = 0;
  int fails = 0;
  int oe_cnt = 0;
  int r8_viol = 0;
  logic [15:0] exp_q [$];
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;

  assign sda_line = sda_m & ~sda_pull_low;

  always #(CLK_NS/2) clk = ~clk;

  xpt_i2c_cmd_port uut (
    .clk (clk), .rst_n (rst_n), .scl_in (scl_m), .sda_in (sda_line),
    .sda_pull_low (sda_pull_low), .dev_sel (dev_sel), .status_byte (status_byte),
    .cmd_valid (cmd_valid), .cmd_word (cmd_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: scoreboard for command words, R8 timing watcher, drive counter
  always @(negedge clk) begin
    if (cmd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R4/R5/R9 unexpected command", cmd_word, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(cmd_word == e, "R3 command word", cmd_word, e);
      end
    end
    if (sda_pull_low) oe_cnt++;
    if (sda_pull_low != prev_oe && scl_m && prev_scl) r8_viol++;
    prev_oe  <= sda_pull_low;
    prev_scl <= scl_m;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q/2);
    acked = ~sda_line;
    wq(Q/2); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q/2); b[i] = sda_line; wq(Q/2); scl_m = 1'b0;
    end
    wq(Q/2); sda_m = give_ack ? 1'b0 : 1'b1; wq(Q/2);
    scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q/2); sda_m = 1'b1; wq(Q/2);
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] pins, input bit rd);
    return {4'b1110, pins, rd};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : driver
    bit ak;
    logic [7:0] rb;
    int base;
    // R9: traffic during reset
    wq(4);
    check(sda_pull_low == 1'b0, "R9 reset sda released", sda_pull_low, 0);
    check(cmd_valid == 1'b0, "R9 reset no strobe", cmd_valid, 0);
    base = oe_cnt;
    bus_start(); send_byte(addr_byte(3'b101, 0), ak);
    check(ak == 1'b0, "R9 no ack in reset", ak, 0);
    send_byte(8'h12, ak); send_byte(8'h34, ak); bus_stop();
    check(oe_cnt == base, "R9 sda untouched in reset", oe_cnt - base, 0);
    rst_n = 1'b1; wq(Q);

    // R1 R3: write with strap 101
    bus_start(); send_byte(addr_byte(3'b101, 0), ak);
    check(ak, "R1 address ack", ak, 1);
    send_byte(8'hA5, ak);
    check(ak, "R3 first byte ack", ak, 1);
    exp_q.push_back(16'hA53C);
    send_byte(8'h3C, ak);
    check(ak, "R3 second byte ack", ak, 1);
    bus_stop();

    // R2: foreign address (bit 1 differs)
    base = oe_cnt;
    bus_start(); send_byte(addr_byte(3'b111, 0), ak);
    check(!ak, "R2 foreign address no ack", ak, 0);
    send_byte(8'hFF, ak); send_byte(8'h00, ak); bus_stop();
    check(oe_cnt == base, "R2 sda never pulled", oe_cnt - base, 0);

    // R4: STOP after one data byte
    bus_start(); send_byte(addr_byte(3'b101, 0), ak);
    send_byte(8'h77, ak); bus_stop();

    // R5: third byte not acked
    bus_start(); send_byte(addr_byte(3'b101, 0), ak);
    send_byte(8'h01, ak);
    exp_q.push_back(16'h0180);
    send_byte(8'h80, ak);
    send_byte(8'h55, ak);
    check(!ak, "R5 third byte nack", ak, 0);
    bus_stop();

    // R10: repeated start after one byte
    bus_start(); send_byte(addr_byte(3'b101, 0), ak);
    send_byte(8'hEE, ak);
    bus_start(); send_byte(addr_byte(3'b101, 0), ak);
    check(ak, "R10 ack after repeated start", ak, 1);
    send_byte(8'h9A, ak);
    exp_q.push_back(16'h9A61);
    send_byte(8'h61, ak); bus_stop();

    // R6: read, strap 101
    status_byte = 8'hB4;
    bus_start(); send_byte(addr_byte(3'b101, 1), ak);
    check(ak, "R1 read address ack", ak, 1);
    recv_byte(1, rb);
    check(rb == 8'h00, "R6 first read byte zero", rb, 8'h00);
    recv_byte(0, rb);
    check(rb == 8'hB4, "R6 status byte", rb, 8'hB4);
    bus_stop();

    // R1 R6: other strap value and status
    dev_sel = 3'b010; status_byte = 8'h4B; wq(Q);
    bus_start(); send_byte(addr_byte(3'b101, 1), ak);
    check(!ak, "R1 old strap rejected", ak, 0);
    bus_stop();
    bus_start(); send_byte(addr_byte(3'b010, 1), ak);
    check(ak, "R1 new strap ack", ak, 1);
    recv_byte(1, rb);
    check(rb == 8'h00, "R6 zero byte", rb, 0);
    recv_byte(0, rb);
    check(rb == 8'h4B, "R6 status byte second", rb, 8'h4B);
    bus_stop();

    // R7: NACK after first byte, then extra clocks
    status_byte = 8'h00;
    bus_start(); send_byte(addr_byte(3'b010, 1), ak);
    recv_byte(0, rb);
    recv_byte(0, rb);
    check(rb == 8'hFF, "R7 released after nack", rb, 8'hFF);
    bus_stop();

    // write with second strap
    bus_start(); send_byte(addr_byte(3'b010, 0), ak);
    send_byte(8'h00, ak);
    exp_q.push_back(16'h00FF);
    send_byte(8'hFF, ak); bus_stop();

    wq(Q);
    check(exp_q.size() == 0, "R3/R10 all commands seen", exp_q.size(), 0);
    check(r8_viol == 0, "R8 sda moved while scl high", r8_viol, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule